// File: doc/BRIEF.md
# Multi-mode capture/compare channel array

An array of dual-purpose timer channels. Each channel holds one register that runs off one of two external time bases (timer A or timer B). It works either as a capture unit or as a compare unit. In capture mode, a chosen edge on the channel's input pin loads the current value of the selected timer into the register and raises a one-cycle interrupt pulse. In compare mode, the channel watches for the selected timer to become equal to the register. On each such match it raises an interrupt pulse and, depending on the compare code, drives the channel's output pin.

Four compare behaviours are offered:
- interrupt only, with any number of matches per timer period;
- toggle the pin on every match;
- interrupt only, at most once per period;
- set the pin on a match and clear it on the timer overflow, at most once per period.

Two options work on top of these. A pairing option lets channel j and channel j+N/2 both toggle the pin of channel j. A single-event option disarms the channel after its first compare event until it is re-armed.

The timers themselves lie outside the block. Their counts and overflow pulses arrive as inputs. Channel configuration and register loads come in through plain input ports.

Top module: `capcmp_array`

## Requirements
- R1: After reset, every pin_o bit, every irq_o bit and every register value on creg_o is zero, and every channel's single-event enable is cleared (disarmed).
- R2: A cycle with wr_i high loads wr_val_i into the register selected by wr_sel_i, and creg_o shows the new value from the next cycle on. When a write and a capture hit the same register in one cycle, the written value wins, but the capture interrupt is still raised.
- R3: tsel_i[k]=0 ties channel k to timer A (tmr_a_i, ovf_a_i), and tsel_i[k]=1 ties it to timer B (tmr_b_i, ovf_b_i). Only the selected timer is compared or captured, and only its overflow pulse acts on the channel.
- R4: mode_i[k] codes 1, 2 and 3 select capture on a rising, falling or either edge of pin_i[k], where an edge is a difference from pin_i[k] one cycle earlier. On such an edge, the register loads the selected timer value of that cycle and irq_o[k] is high for exactly the following cycle. In capture modes, pin_o[k] holds its value.
- R5: mode_i[k] codes 4 to 7 are compare modes. A compare event happens in a cycle where the selected timer equals the register and did not equal it in the previous cycle. Every compare event drives irq_o[k] high for exactly the following cycle. Code 0 turns the channel off: no interrupts and no pin change.
- R6: Code 4 raises an interrupt on every compare event, any number of times per period, and leaves pin_o[k] unchanged.
- R7: Code 5 inverts pin_o[k] on every compare event, any number of times per period.
- R8: Code 6 raises an interrupt only and allows at most one compare event until the selected timer's overflow pulse re-arms the channel.
- R9: Code 7 sets pin_o[k] on a compare event and clears it on the selected overflow pulse. It allows one event per period, re-armed by that overflow. A compare event in the same cycle as the overflow wins, and the pin ends up set.
- R10: With dbl_i[j] high (j < N/2), a compare event of channel j or channel j+N/2 inverts pin_o[j], whatever their compare codes. Events of both channels in one cycle invert it only once. pin_o[j+N/2] is held at 0.
- R11: With sngl_i[k] high, compare events happen only while the channel's enable is set. The first event clears the enable, and a one-cycle pulse on arm_i[k] sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_a_i | input | TW | Count of timer A |
| tmr_b_i | input | TW | Count of timer B |
| ovf_a_i | input | 1 | One-cycle overflow pulse of timer A |
| ovf_b_i | input | 1 | One-cycle overflow pulse of timer B |
| mode_i | input | N_CH x 3 | Per-channel mode code (0 off, 1-3 capture, 4-7 compare) |
| tsel_i | input | N_CH | Per-channel timer select (0 = A, 1 = B) |
| sngl_i | input | N_CH | Per-channel single-event option |
| dbl_i | input | N_CH/2 | Per-pair register pairing option |
| arm_i | input | N_CH | Per-channel re-arm pulse for single-event |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | clog2(N_CH) | Index of the register to write |
| wr_val_i | input | TW | Value to write |
| pin_i | input | N_CH | Capture trigger inputs |
| pin_o | output | N_CH | Compare output levels |
| irq_o | output | N_CH | One-cycle interrupt pulses |
| creg_o | output | N_CH x TW | Current register values |

## Verification
The bench builds the array with the default 16 channels and an 8-bit timer width. Sixteen channels give eight pairs, so a low channel and its partner eight positions higher can run the pairing option next to channels that use every other mode. The narrow timer keeps the match values and overflow pulses short. The bench places timer values one by one, so it can land a match in the same cycle as an overflow, match again within a period, and place pin edges next to register writes.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef enum logic [2:0] {
    MD_OFF        = 3'd0,
    MD_CAP_RISE   = 3'd1,
    MD_CAP_FALL   = 3'd2,
    MD_CAP_BOTH   = 3'd3,
    MD_CMP_MULTI  = 3'd4,
    MD_CMP_TOGGLE = 3'd5,
    MD_CMP_ONCE   = 3'd6,
    MD_CMP_SETCLR = 3'd7
  } ch_mode_e;
endpackage

// File: rtl/capcmp_chan.sv
module capcmp_chan
  import capcmp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          tsel_i,
  input  logic          sngl_i,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          ovf_a_i,
  input  logic          ovf_b_i,
  input  logic          pin_i,
  input  logic          wr_i,
  input  logic [TW-1:0] wr_val_i,
  input  logic          arm_i,
  output logic          cmp_evt_o,
  output logic          ovf_o,
  output logic          irq_o,
  output logic [TW-1:0] val_o
);
  ch_mode_e      md;
  logic [TW-1:0] tmr_sel, val_q;
  logic          eq, eq_q, pin_q, done_q, arm_q, irq_q;
  logic          once_mode, blocked, rise, fall, cap_evt;

  assign md      = ch_mode_e'(mode_i);
  assign tmr_sel = tsel_i ? tmr_b_i : tmr_a_i;
  assign ovf_o   = tsel_i ? ovf_b_i : ovf_a_i;
  assign eq      = (tmr_sel == val_q);

  assign once_mode = (md == MD_CMP_ONCE) || (md == MD_CMP_SETCLR);
  // once-per-period lockout and single-event disarm
  assign blocked   = (once_mode && done_q) || (sngl_i && !arm_q);
  assign cmp_evt_o = mode_i[2] && eq && !eq_q && !blocked;

  assign rise = pin_i && !pin_q;
  assign fall = !pin_i && pin_q;

  always_comb begin
    case (md)
      MD_CAP_RISE: cap_evt = rise;
      MD_CAP_FALL: cap_evt = fall;
      MD_CAP_BOTH: cap_evt = rise || fall;
      default:     cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      eq_q   <= 1'b0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      arm_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      eq_q  <= eq;
      pin_q <= pin_i;
      irq_q <= cmp_evt_o || cap_evt;
      if (wr_i)         val_q <= wr_val_i;
      else if (cap_evt) val_q <= tmr_sel;
      if (cmp_evt_o)    done_q <= 1'b1;
      else if (ovf_o)   done_q <= 1'b0;
      if (cmp_evt_o && sngl_i) arm_q <= 1'b0;
      else if (arm_i)          arm_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;
  assign val_o = val_q;
endmodule

// File: rtl/capcmp_pin.sv
module capcmp_pin
  import capcmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       ovf_i,
  input  logic       evt_i,
  input  logic       pair_evt_i,
  input  logic       lead_i,
  input  logic       follow_i,
  output logic       pin_o
);
  ch_mode_e md;
  logic     pin_q;

  assign md = ch_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (follow_i) begin
      pin_q <= 1'b0;
    end else if (lead_i) begin
      if (evt_i || pair_evt_i) pin_q <= !pin_q;
    end else begin
      case (md)
        MD_CMP_TOGGLE: if (evt_i) pin_q <= !pin_q;
        MD_CMP_SETCLR: begin
          if (evt_i)      pin_q <= 1'b1;
          else if (ovf_i) pin_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/capcmp_array.sv
module capcmp_array
  import capcmp_pkg::*;
#(
  parameter  int N_CH = 16,
  parameter  int TW   = 16,
  localparam int IW   = $clog2(N_CH),
  localparam int HALF = N_CH / 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [TW-1:0]            tmr_a_i,
  input  logic [TW-1:0]            tmr_b_i,
  input  logic                     ovf_a_i,
  input  logic                     ovf_b_i,
  input  logic [N_CH-1:0][2:0]     mode_i,
  input  logic [N_CH-1:0]          tsel_i,
  input  logic [N_CH-1:0]          sngl_i,
  input  logic [HALF-1:0]          dbl_i,
  input  logic [N_CH-1:0]          arm_i,
  input  logic                     wr_i,
  input  logic [IW-1:0]            wr_sel_i,
  input  logic [TW-1:0]            wr_val_i,
  input  logic [N_CH-1:0]          pin_i,
  output logic [N_CH-1:0]          pin_o,
  output logic [N_CH-1:0]          irq_o,
  output logic [N_CH-1:0][TW-1:0]  creg_o
);
  logic [N_CH-1:0] cmp_evt;
  logic [N_CH-1:0] ovf_sel;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic wr_hit, pair_evt, lead, follow;

    assign wr_hit = wr_i && (wr_sel_i == IW'(i));

    capcmp_chan #(.TW(TW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_i[i]),
      .tsel_i    (tsel_i[i]),
      .sngl_i    (sngl_i[i]),
      .tmr_a_i   (tmr_a_i),
      .tmr_b_i   (tmr_b_i),
      .ovf_a_i   (ovf_a_i),
      .ovf_b_i   (ovf_b_i),
      .pin_i     (pin_i[i]),
      .wr_i      (wr_hit),
      .wr_val_i  (wr_val_i),
      .arm_i     (arm_i[i]),
      .cmp_evt_o (cmp_evt[i]),
      .ovf_o     (ovf_sel[i]),
      .irq_o     (irq_o[i]),
      .val_o     (creg_o[i])
    );

    // lower half leads a pair, upper half follows
    if (i < HALF) begin : g_lo
      assign pair_evt = cmp_evt[i+HALF];
      assign lead     = dbl_i[i];
      assign follow   = 1'b0;
    end else begin : g_hi
      assign pair_evt = 1'b0;
      assign lead     = 1'b0;
      assign follow   = dbl_i[i-HALF];
    end

    capcmp_pin u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode_i[i]),
      .ovf_i      (ovf_sel[i]),
      .evt_i      (cmp_evt[i]),
      .pair_evt_i (pair_evt),
      .lead_i     (lead),
      .follow_i   (follow),
      .pin_o      (pin_o[i])
    );
  end
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk #(
  parameter  int N_CH = 16,
  parameter  int TW   = 16,
  localparam int IW   = $clog2(N_CH),
  localparam int HALF = N_CH / 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ovf_a_i,
  input logic                     ovf_b_i,
  input logic [N_CH-1:0][2:0]     mode_i,
  input logic [N_CH-1:0]          tsel_i,
  input logic [HALF-1:0]          dbl_i,
  input logic [N_CH-1:0]          pin_o,
  input logic [N_CH-1:0]          irq_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_c
    logic dbl_c, ovf_c;
    assign ovf_c = tsel_i[i] ? ovf_b_i : ovf_a_i;

    if (i < HALF) begin : g_lo
      assign dbl_c = dbl_i[i];
    end else begin : g_hi
      assign dbl_c = dbl_i[i-HALF];
      // R10
      follow_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbl_c |=> !pin_o[i]);
    end

    // R5
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == 3'd0) |=> !irq_o[i]);

    // R7
    toggle_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == 3'd5 && !dbl_c) |=> ((pin_o[i] != $past(pin_o[i])) == irq_o[i]));

    // R4
    cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] != 3'd0 && !mode_i[i][2] && !dbl_c) |=> $stable(pin_o[i]));

    // R9
    setclr_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == 3'd7 && !dbl_c && ovf_c) |=> (!pin_o[i] || irq_o[i]));
  end
endmodule

bind capcmp_array capcmp_chk #(.N_CH(N_CH), .TW(TW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ovf_a_i (ovf_a_i),
  .ovf_b_i (ovf_b_i),
  .mode_i  (mode_i),
  .tsel_i  (tsel_i),
  .dbl_i   (dbl_i),
  .pin_o   (pin_o),
  .irq_o   (irq_o)
);

// File: tb/capcmp_array_bench.sv
module capcmp_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int TW = 8;
  localparam int IW = $clog2(N);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [TW-1:0]       tmr_a = 8'd200, tmr_b = 8'd200;
  logic                ovf_a = 1'b0, ovf_b = 1'b0;
  logic [N-1:0][2:0]   mode = '0;
  logic [N-1:0]        tsel = '0, sngl = '0, arm = '0, pin_in = '0;
  logic [N/2-1:0]      dbl = '0;
  logic                wr = 1'b0;
  logic [IW-1:0]       wr_sel = '0;
  logic [TW-1:0]       wr_val = '0;
  logic [N-1:0]        pin_out, irq;
  logic [N-1:0][TW-1:0] creg;

  capcmp_array #(.N_CH(N), .TW(TW)) u_capcmp_array (
    .clk_i(clk), .rst_ni(rst_n), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .ovf_a_i(ovf_a), .ovf_b_i(ovf_b), .mode_i(mode), .tsel_i(tsel),
    .sngl_i(sngl), .dbl_i(dbl), .arm_i(arm), .wr_i(wr), .wr_sel_i(wr_sel),
    .wr_val_i(wr_val), .pin_i(pin_in), .pin_o(pin_out), .irq_o(irq),
    .creg_o(creg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit run = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int ch; int cyc; string req; } exp_t;
  exp_t sbq[$];

  task automatic expect_irq(int ch, string req);
    exp_t e;
    e.ch = ch; e.cyc = cyc + 1; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: pops expected interrupt pulses in channel order
  always @(negedge clk) begin
    exp_t e;
    if (run) begin
      while (sbq.size() != 0 && sbq[0].cyc < cyc) begin
        e = sbq.pop_front();
        n_chk++; n_fail++;
        $display("FAIL %s missing irq ch%0d: got 0 expected 1 at cycle %0d", e.req, e.ch, e.cyc);
      end
      for (int c = 0; c < N; c++) begin
        if (irq[c]) begin
          n_chk++;
          if (sbq.size() == 0 || sbq[0].cyc != cyc || sbq[0].ch != c) begin
            n_fail++;
            $display("FAIL R5 unexpected irq ch%0d cycle %0d: got 1 expected 0", c, cyc);
          end else begin
            e = sbq.pop_front();
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(int ch, int val);
    wr = 1'b1; wr_sel = IW'(ch); wr_val = TW'(val);
    step();
    wr = 1'b0;
    chk("R2", $sformatf("creg[%0d] after write", ch), int'(creg[ch]), val);
  endtask

  task automatic main_seq();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    run = 1'b1;
    // R1 reset state
    chk("R1", "pin_o after reset", int'(pin_out), 0);
    chk("R1", "irq_o after reset", int'(irq), 0);
    for (int c = 0; c < N; c++) chk("R1", "creg after reset", int'(creg[c]), 0);

    // R2 loads
    wr_reg(0, 10); wr_reg(1, 20); wr_reg(2, 30); wr_reg(3, 40);
    wr_reg(4, 60); wr_reg(7, 50); wr_reg(12, 65); wr_reg(14, 90);
    wr_reg(15, 90);

    mode[0] = 3'd4; mode[1] = 3'd5; mode[2] = 3'd6;
    mode[3] = 3'd7; tsel[3] = 1'b1;
    mode[7] = 3'd5; sngl[7] = 1'b1;
    mode[4] = 3'd4; mode[12] = 3'd5; dbl[4] = 1'b1;
    mode[10] = 3'd1; mode[11] = 3'd3; tsel[11] = 1'b1; mode[13] = 3'd2;
    mode[14] = 3'd0; mode[15] = 3'd4; tsel[15] = 1'b1;
    step();

    // R6 interrupt only, repeated within a period
    tmr_a = 8'd10; expect_irq(0, "R6"); step();
    chk("R6", "pin0 after match", int'(pin_out[0]), 0);
    tmr_a = 8'd11; step();
    tmr_a = 8'd10; expect_irq(0, "R6"); step();
    chk("R6", "pin0 after second match", int'(pin_out[0]), 0);

    // R7 toggle
    tmr_a = 8'd20; expect_irq(1, "R7"); step();
    chk("R7", "pin1 first toggle", int'(pin_out[1]), 1);
    tmr_a = 8'd21; step();
    tmr_a = 8'd20; expect_irq(1, "R7"); step();
    chk("R7", "pin1 second toggle", int'(pin_out[1]), 0);

    // R8 once per period
    tmr_a = 8'd30; expect_irq(2, "R8"); step();
    tmr_a = 8'd31; step();
    tmr_a = 8'd30; step();
    chk("R8", "irq2 second match same period", int'(irq[2]), 0);
    tmr_a = 8'd31; ovf_a = 1'b1; step();
    ovf_a = 1'b0;
    tmr_a = 8'd30; expect_irq(2, "R8"); step();

    // R9 set on match, clear on own overflow; R3 other timer's overflow ignored
    tmr_b = 8'd40; expect_irq(3, "R9"); step();
    chk("R9", "pin3 set", int'(pin_out[3]), 1);
    tmr_b = 8'd41; step();
    tmr_b = 8'd40; step();
    chk("R9", "irq3 second match same period", int'(irq[3]), 0);
    chk("R9", "pin3 held", int'(pin_out[3]), 1);
    tmr_b = 8'd41; ovf_a = 1'b1; step();
    ovf_a = 1'b0;
    chk("R3", "pin3 after timer A overflow", int'(pin_out[3]), 1);
    ovf_b = 1'b1; step();
    ovf_b = 1'b0;
    chk("R9", "pin3 after timer B overflow", int'(pin_out[3]), 0);
    tmr_b = 8'd40; expect_irq(3, "R9"); step();
    chk("R9", "pin3 set again", int'(pin_out[3]), 1);
    tmr_b = 8'd41; ovf_b = 1'b1; step();
    chk("R9", "pin3 cleared", int'(pin_out[3]), 0);
    ovf_b = 1'b1; tmr_b = 8'd40; expect_irq(3, "R9"); step();
    ovf_b = 1'b0;
    chk("R9", "pin3 match beats overflow", int'(pin_out[3]), 1);

    // R11 single event, R1 disarmed from reset
    tmr_a = 8'd50; step();
    chk("R11", "irq7 while disarmed (R1)", int'(irq[7]), 0);
    tmr_a = 8'd51; arm[7] = 1'b1; step();
    arm[7] = 1'b0;
    tmr_a = 8'd50; expect_irq(7, "R11"); step();
    chk("R11", "pin7 armed toggle", int'(pin_out[7]), 1);
    tmr_a = 8'd51; step();
    tmr_a = 8'd50; step();
    chk("R11", "irq7 after disarm", int'(irq[7]), 0);
    chk("R11", "pin7 after disarm", int'(pin_out[7]), 1);
    tmr_a = 8'd51; arm[7] = 1'b1; step();
    arm[7] = 1'b0;
    tmr_a = 8'd50; expect_irq(7, "R11"); step();
    chk("R11", "pin7 re-armed toggle", int'(pin_out[7]), 0);

    // R10 paired registers
    tmr_a = 8'd60; expect_irq(4, "R10"); step();
    chk("R10", "pin4 after ch4 match", int'(pin_out[4]), 1);
    chk("R10", "pin12 held low", int'(pin_out[12]), 0);
    tmr_a = 8'd65; expect_irq(12, "R10"); step();
    chk("R10", "pin4 after ch12 match", int'(pin_out[4]), 0);
    chk("R10", "pin12 held low after match", int'(pin_out[12]), 0);
    wr_reg(12, 60);
    tmr_a = 8'd61; step();
    tmr_a = 8'd60; expect_irq(4, "R10"); expect_irq(12, "R10"); step();
    chk("R10", "pin4 single toggle on double match", int'(pin_out[4]), 1);

    // R4 capture
    tmr_a = 8'd77; pin_in[10] = 1'b1; expect_irq(10, "R4"); step();
    chk("R4", "creg10 rising capture", int'(creg[10]), 77);
    tmr_a = 8'd78; pin_in[10] = 1'b0; step();
    chk("R4", "creg10 falling ignored", int'(creg[10]), 77);
    chk("R4", "pin10 held", int'(pin_out[10]), 0);
    tmr_b = 8'd55; pin_in[11] = 1'b1; expect_irq(11, "R4"); step();
    chk("R4", "creg11 rise on timer B", int'(creg[11]), 55);
    tmr_b = 8'd56; pin_in[11] = 1'b0; expect_irq(11, "R4"); step();
    chk("R4", "creg11 fall on timer B", int'(creg[11]), 56);
    pin_in[13] = 1'b1; step();
    chk("R4", "creg13 rise ignored", int'(creg[13]), 0);
    tmr_a = 8'd79; pin_in[13] = 1'b0; expect_irq(13, "R4"); step();
    chk("R4", "creg13 falling capture", int'(creg[13]), 79);
    // R2 write beats capture
    tmr_a = 8'd80; pin_in[10] = 1'b1; wr = 1'b1; wr_sel = 4'd10; wr_val = 8'd5;
    expect_irq(10, "R2"); step();
    wr = 1'b0;
    chk("R2", "creg10 write over capture", int'(creg[10]), 5);

    // R3 timer select, R5 off channel
    tmr_a = 8'd90; step();
    chk("R3", "irq15 on unselected timer", int'(irq[15]), 0);
    chk("R5", "irq14 while off", int'(irq[14]), 0);
    tmr_b = 8'd90; expect_irq(15, "R3"); step();
    chk("R5", "pin14 while off", int'(pin_out[14]), 0);
    repeat (3) step();
    n_chk++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL R5 pending irq: got %0d expected 0", sbq.size());
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule